// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block is a bank of identical 16-bit timer channels. Software programs them through a small word-addressed register port made of address, write strobe, write data and combinational read data. Each channel counts prescaled ticks from one of three sources: the core clock, a slow real-time tick enable or an external tick enable. The alternate sources are treated as synchronous one-cycle enables. A channel raises a half-match event when its count reaches the duty value and a full-match event when it reaches the period value, and it then wraps to zero. The duty value also shapes a pulse-width output, which can be inverted and shut down either at once or at the end of the current period.

The global channel-enable, channel-stop, event-flag and interrupt-mask words each have a write-one-to-set alias and a write-one-to-clear alias, so one channel can be changed without a read-modify-write cycle. The plain addresses of these words can only be read. A single interrupt line is raised while any flag is set whose mask bit is clear.

Top module: `pwm_timer_bank`

## Requirements
- R1: Global words are read at 0x00 (enable), 0x0C (stop), 0x10 (flag) and 0x20 (mask). A write to a set alias (0x04, 0x1C, 0x14, 0x24) sets every bit written as 1. A write to a clear alias (0x08, 0x2C, 0x18, 0x28) clears every bit written as 1. Bits written as 0 do not change, and writes to the plain read addresses are ignored.
- R2: After reset, every implemented mask bit reads 1, so with 8 channels the mask reads 0x00FF00FF. Enable, stop, flag and all channel registers read 0, and the interrupt and PWM outputs are 0.
- R3: A channel counts while its enable bit is 1 and its stop bit is 0. Setting the stop bit holds the count. The counter can be read and overwritten by software.
- R4: Control bits 5:3 select the prescale: codes 0 to 5 divide the selected tick source by 1, 4, 16, 64, 256 and 1024, and codes 6 and 7 also divide by 1024.
- R5: Control bit 0 selects the core clock, bit 1 the real-time tick and bit 2 the external tick as the counting source. A source whose bit is 0 has no effect on the count.
- R6: The count runs 0, 1, ..., period and then wraps to 0. Reaching the period value sets flag bit n, and reaching the duty value sets flag bit n+16, where n is the channel number.
- R7: With control bit 7 set, PWM output n is active while the count is below the duty value and inactive otherwise. Control bit 8 inverts it, so the active level is 0.
- R8: When bit 7 is cleared while bit 9 is 1, the output goes to its inactive level at once. When bit 7 is cleared while bit 9 is 0, the output keeps its waveform until the count wraps and then stays inactive.
- R9: The interrupt output is 1 exactly when some flag bit is 1 whose mask bit is 0.
- R10: Channel n has its period at 0x30+0x10*n, its duty at +0x4, its counter at +0x8 and its 10-bit control word at +0xC. Each reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the core-clock counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | Real-time tick enable, one cycle per tick |
| ext_tick | input | 1 | External tick enable, one cycle per tick |
| bus_addr | input | AW (8) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH (8) | PWM output of each channel |
| irq | output | 1 | Combined interrupt request |

## Verification
Channel 0 is run at full clock rate with a short period, and its PWM output is compared cycle by cycle with the waveform derived from the count sequence. This separates an off-by-one in the wrap from an off-by-one in the duty compare. The graceful and abrupt shutdown patterns are started from a known stopped count, so a one-period tail can be told apart from an immediate cut and from a missing polarity inversion. The prescale codes for divide-by-4, divide-by-16 and divide-by-1024 are checked by exact counter values after a fixed number of cycles. Interleaved real-time and external tick pulses show that only the selected source advances the count. Pairs of set and clear writes with chosen bit patterns tell a write-one-to-set alias apart from a plain overwrite.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned PRE_W   = 10;   // widest divider is 1024
  localparam int unsigned CTRL_W  = 10;
  localparam int unsigned HALF_SH = 16;   // half-match flags sit above full-match flags

  localparam int unsigned CB_SRC_CLK = 0;
  localparam int unsigned CB_SRC_RTC = 1;
  localparam int unsigned CB_SRC_EXT = 2;
  localparam int unsigned CB_PRE_LO  = 3;
  localparam int unsigned CB_PWM_ON  = 7;
  localparam int unsigned CB_PWM_LOW = 8;
  localparam int unsigned CB_PWM_CUT = 9;

  localparam int unsigned OFS_EN      = 'h00;
  localparam int unsigned OFS_EN_SET  = 'h04;
  localparam int unsigned OFS_EN_CLR  = 'h08;
  localparam int unsigned OFS_STP     = 'h0C;
  localparam int unsigned OFS_FLG     = 'h10;
  localparam int unsigned OFS_FLG_SET = 'h14;
  localparam int unsigned OFS_FLG_CLR = 'h18;
  localparam int unsigned OFS_STP_SET = 'h1C;
  localparam int unsigned OFS_MSK     = 'h20;
  localparam int unsigned OFS_MSK_SET = 'h24;
  localparam int unsigned OFS_MSK_CLR = 'h28;
  localparam int unsigned OFS_STP_CLR = 'h2C;
  localparam int unsigned OFS_CH0     = 'h30;
  localparam int unsigned CH_STRIDE   = 'h10;

  typedef enum logic [1:0] {
    CR_PERIOD = 2'd0,
    CR_DUTY   = 2'd1,
    CR_COUNT  = 2'd2,
    CR_CTRL   = 2'd3
  } ch_reg_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       src,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_d, lim;

  always_comb begin
    if (code >= 3'd5) lim = '1;
    else              lim = PRE_W'((32'd1 << {code, 1'b0}) - 32'd1);
  end

  assign tick = run & src & (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (!run)      pre_d = '0;
    else if (tick) pre_d = '0;
    else if (src)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) tick |=> (pre_q == '0)); // R4
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (pre_q == '0)); // R3
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rtc_tick,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  ch_reg_e           wr_sel,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     period_o,
  output logic [CW-1:0]     duty_o,
  output logic [CW-1:0]     count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              half_evt,
  output logic              full_evt,
  output logic              pwm_o
);
  logic [CW-1:0]     period_q, duty_q, cnt_q, cnt_d, cnt_inc;
  logic [CTRL_W-1:0] ctrl_q;
  logic              tail_q, tail_d, src, tick, cnt_we, wrap, live;

  assign src = (ctrl_q[CB_SRC_CLK])
             | (ctrl_q[CB_SRC_RTC] & rtc_tick)
             | (ctrl_q[CB_SRC_EXT] & ext_tick);

  pwm_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .src  (src),
    .code (ctrl_q[CB_PRE_LO +: 3]),
    .tick (tick)
  );

  assign cnt_we  = wr_en && (wr_sel == CR_COUNT);
  assign cnt_inc = (cnt_q == period_q) ? '0 : cnt_q + 1'b1;
  assign wrap    = tick & ~cnt_we & (cnt_q == period_q);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)    cnt_d = wr_data;
    else if (tick) cnt_d = cnt_inc;
  end

  assign half_evt = tick & ~cnt_we & (cnt_inc == duty_q);
  assign full_evt = tick & ~cnt_we & (cnt_inc == period_q);

  always_comb begin
    if (ctrl_q[CB_PWM_ON]) tail_d = 1'b1;
    else                   tail_d = tail_q & ~ctrl_q[CB_PWM_CUT] & ~wrap;
  end

  assign live  = ctrl_q[CB_PWM_ON] | (tail_q & ~ctrl_q[CB_PWM_CUT]);
  assign pwm_o = (live & (cnt_q < duty_q)) ^ ctrl_q[CB_PWM_LOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
      cnt_q    <= '0;
      tail_q   <= 1'b0;
    end else begin
      if (wr_en && wr_sel == CR_PERIOD) period_q <= wr_data;
      if (wr_en && wr_sel == CR_DUTY)   duty_q   <= wr_data;
      if (wr_en && wr_sel == CR_CTRL)   ctrl_q   <= wr_data[CTRL_W-1:0];
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
    end
  end

  assign period_o = period_q;
  assign duty_o   = duty_q;
  assign count_o  = cnt_q;
  assign ctrl_o   = ctrl_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !cnt_we && cnt_q == period_q) |=> (cnt_q == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !cnt_we) |=> $stable(cnt_q)); // R3
  AST_ABRUPT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_q[CB_PWM_ON] && ctrl_q[CB_PWM_CUT]) |-> (pwm_o == ctrl_q[CB_PWM_LOW])); // R8
endmodule

// File: rtl/pwm_glob_regs.sv
module pwm_glob_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  input  logic [NCH-1:0] half_evt,
  input  logic [NCH-1:0] full_evt,
  output logic [NCH-1:0] en_q,
  output logic [NCH-1:0] stop_q,
  output logic [31:0]    flag_q,
  output logic [31:0]    mask_q
);
  localparam logic [15:0] CH_BITS = 16'((32'd1 << NCH) - 32'd1);
  localparam logic [31:0] IMPL    = {CH_BITS, CH_BITS};

  logic [NCH-1:0] en_d, stop_d, wch;
  logic [31:0]    flag_d, mask_d, evt;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  assign wch = wdata[NCH-1:0];
  assign evt = {16'(half_evt), 16'(full_evt)};

  always_comb begin
    en_d   = en_q;
    stop_d = stop_q;
    flag_d = flag_q;
    mask_d = mask_q;
    if (we) begin
      if (hit(addr, OFS_EN_SET))  en_d   = en_q | wch;
      if (hit(addr, OFS_EN_CLR))  en_d   = en_q & ~wch;
      if (hit(addr, OFS_STP_SET)) stop_d = stop_q | wch;
      if (hit(addr, OFS_STP_CLR)) stop_d = stop_q & ~wch;
      if (hit(addr, OFS_FLG_SET)) flag_d = flag_q | wdata;
      if (hit(addr, OFS_FLG_CLR)) flag_d = flag_q & ~wdata;
      if (hit(addr, OFS_MSK_SET)) mask_d = mask_q | wdata;
      if (hit(addr, OFS_MSK_CLR)) mask_d = mask_q & ~wdata;
    end
    flag_d = (flag_d | evt) & IMPL;
    mask_d = mask_d & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stop_q <= '0;
      flag_q <= '0;
      mask_q <= IMPL;
    end else begin
      en_q   <= en_d;
      stop_q <= stop_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == AW'(OFS_EN_SET)) |=> ((en_q & $past(wch)) == $past(wch))); // R1
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == AW'(OFS_MSK_CLR)) |=> ((mask_q & $past(wdata)) == 32'd0)); // R1
  AST_FLAG_EVT: assert property (@(posedge clk) disable iff (!rst_n) (full_evt[0]) |=> flag_q[0]); // R6
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rtc_tick,
  input  logic           ext_tick,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);
  localparam int unsigned IW     = $clog2(NCH);
  localparam int unsigned CH_END = OFS_CH0 + NCH * CH_STRIDE;

  logic [1:0]    rst_sync;
  logic          core_rst_n;
  logic [AW-1:0] ch_off;
  logic [IW-1:0] ch_idx;
  logic          in_ch;
  ch_reg_e       ch_sel;

  logic [NCH-1:0] en_q, stop_q, half_evt, full_evt, ch_we;
  logic [31:0]    flag_q, mask_q;
  logic [CW-1:0]     per_r [NCH];
  logic [CW-1:0]     duty_r[NCH];
  logic [CW-1:0]     cnt_r [NCH];
  logic [CTRL_W-1:0] ctrl_r[NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign ch_off = bus_addr - AW'(OFS_CH0);
  assign ch_idx = ch_off[4 +: IW];
  assign ch_sel = ch_reg_e'(bus_addr[3:2]);
  assign in_ch  = (bus_addr >= AW'(OFS_CH0)) && (32'(bus_addr) < CH_END) && (bus_addr[1:0] == 2'b00);

  pwm_glob_regs #(.NCH(NCH), .AW(AW)) u_glob (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .half_evt(half_evt),
    .full_evt(full_evt),
    .en_q    (en_q),
    .stop_q  (stop_q),
    .flag_q  (flag_q),
    .mask_q  (mask_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_we[i] = bus_we & in_ch & (ch_idx == IW'(i));
    pwm_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .run     (en_q[i] & ~stop_q[i]),
      .rtc_tick(rtc_tick),
      .ext_tick(ext_tick),
      .wr_en   (ch_we[i]),
      .wr_sel  (ch_sel),
      .wr_data (bus_wdata[CW-1:0]),
      .period_o(per_r[i]),
      .duty_o  (duty_r[i]),
      .count_o (cnt_r[i]),
      .ctrl_o  (ctrl_r[i]),
      .half_evt(half_evt[i]),
      .full_evt(full_evt[i]),
      .pwm_o   (pwm_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (in_ch) begin
      unique case (ch_sel)
        CR_PERIOD: bus_rdata = 32'(per_r[ch_idx]);
        CR_DUTY:   bus_rdata = 32'(duty_r[ch_idx]);
        CR_COUNT:  bus_rdata = 32'(cnt_r[ch_idx]);
        CR_CTRL:   bus_rdata = 32'(ctrl_r[ch_idx]);
      endcase
    end else if (bus_addr == AW'(OFS_EN))  bus_rdata = 32'(en_q);
    else if (bus_addr == AW'(OFS_STP))     bus_rdata = 32'(stop_q);
    else if (bus_addr == AW'(OFS_FLG))     bus_rdata = flag_q;
    else if (bus_addr == AW'(OFS_MSK))     bus_rdata = mask_q;
  end

  assign irq = |(flag_q & ~mask_q);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n) (flag_q == 32'd0) |-> !irq); // R9
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!core_rst_n) (flag_q[0] && !mask_q[0]) |-> irq); // R9
endmodule

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { bit exp; int ch; string tag; } wave_t;
  wave_t wave_q[$];

  always #2 clk = ~clk;

  pwm_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 check(bus_rdata, exp, tag);
  endtask

  task automatic push_wave(input int ch, input bit e, input string tag);
    wave_t w;
    w.ch = ch; w.exp = e; w.tag = tag;
    wave_q.push_back(w);
  endtask

  task automatic drain();
    while (wave_q.size() > 0) @(posedge clk);
  endtask

  task automatic pulse_rtc();
    @(negedge clk) rtc_tick = 1'b1;
    @(negedge clk) rtc_tick = 1'b0;
  endtask

  task automatic pulse_ext();
    @(negedge clk) ext_tick = 1'b1;
    @(negedge clk) ext_tick = 1'b0;
  endtask

  // monitor: compares the PWM output against the expected queue each cycle
  always @(negedge clk) begin
    if (wave_q.size() > 0) begin
      wave_t w;
      w = wave_q.pop_front();
      check(32'(pwm_out[w.ch]), 32'(w.exp), w.tag);
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(8'h00, 32'h0, "R2 enable reset");
    rd(8'h0C, 32'h0, "R2 stop reset");
    rd(8'h10, 32'h0, "R2 flag reset");
    rd(8'h20, 32'h00FF00FF, "R2 mask reset");
    rd(8'h3C, 32'h0, "R2 ctrl reset");
    check(32'(irq), 32'd0, "R2 irq reset");
    check(32'(pwm_out), 32'd0, "R2 pwm reset");

    // R1 set/clear aliases
    wr(8'h04, 32'h05); rd(8'h00, 32'h05, "R1 enable set");
    wr(8'h08, 32'h04); rd(8'h00, 32'h01, "R1 enable clear one bit");
    wr(8'h08, 32'h01); rd(8'h00, 32'h00, "R1 enable clear last");
    wr(8'h1C, 32'hF0); rd(8'h0C, 32'hF0, "R1 stop set");
    wr(8'h2C, 32'h30); rd(8'h0C, 32'hC0, "R1 stop clear partial");
    wr(8'h2C, 32'hC0);
    wr(8'h00, 32'hFF); rd(8'h00, 32'h00, "R1 plain address write ignored");
    wr(8'h28, 32'h00010001); rd(8'h20, 32'h00FE00FE, "R1 mask clear");
    wr(8'h24, 32'h00010001); rd(8'h20, 32'h00FF00FF, "R1 mask set");

    // R10 channel map
    wr(8'h30, 32'd5); wr(8'h34, 32'd2); wr(8'h3C, 32'h081);
    rd(8'h30, 32'd5, "R10 period readback");
    rd(8'h34, 32'd2, "R10 duty readback");
    rd(8'h3C, 32'h081, "R10 ctrl readback");
    wr(8'h70, 32'h0000ABCD); rd(8'h70, 32'h0000ABCD, "R10 channel 4 period");
    rd(8'h30, 32'd5, "R10 channel 0 untouched");

    // R7 R6 waveform: period 5, duty 2, full clock rate
    wr(8'h04, 32'h01);
    for (int k = 0; k < 18; k++) push_wave(0, (k % 6) < 2, "R7 waveform");
    drain();
    rd(8'h10, 32'h00010001, "R6 half and full flags");
    check(32'(irq), 32'd0, "R9 masked flags");
    wr(8'h28, 32'h00010000);
    check(32'(irq), 32'd1, "R9 unmasked half flag");
    wr(8'h1C, 32'h01);
    wr(8'h18, 32'h00010001);
    rd(8'h10, 32'h0, "R1 flag clear");
    check(32'(irq), 32'd0, "R9 irq drops after clear");
    wr(8'h14, 32'h08); rd(8'h10, 32'h08, "R1 flag set alias");
    check(32'(irq), 32'd0, "R9 masked set flag");
    wr(8'h18, 32'h08);

    // R8 graceful shutdown from count 3, duty 4, period 5
    wr(8'h34, 32'd4); wr(8'h38, 32'd3);
    check(32'(pwm_out[0]), 32'd1, "R7 active below duty");
    wr(8'h3C, 32'h001);
    check(32'(pwm_out[0]), 32'd1, "R8 graceful keeps waveform");
    wr(8'h2C, 32'h01);
    push_wave(0, 1'b1, "R8 graceful tail");
    for (int k = 0; k < 8; k++) push_wave(0, 1'b0, "R8 graceful off after wrap");
    drain();
    wr(8'h1C, 32'h01);
    wr(8'h38, 32'd1); wr(8'h3C, 32'h181);
    check(32'(pwm_out[0]), 32'd0, "R7 active-low active level");
    wr(8'h3C, 32'h301);
    check(32'(pwm_out[0]), 32'd1, "R8 abrupt cut active-low");
    wr(8'h3C, 32'h201);
    check(32'(pwm_out[0]), 32'd0, "R8 abrupt cut active-high");

    // R4 divide by 16 on channel 1
    wr(8'h40, 32'hFFFF); wr(8'h4C, 32'h011);
    wr(8'h04, 32'h02);
    repeat (160) @(posedge clk);
    #1 rd(8'h48, 32'd10, "R4 divide by 16");
    wr(8'h1C, 32'h02);
    repeat (100) @(posedge clk);
    rd(8'h48, 32'd10, "R3 stop holds count");
    wr(8'h48, 32'h1234); rd(8'h48, 32'h1234, "R3 counter overwrite");

    // R4 divide by 4 on channel 3
    wr(8'h60, 32'hFFFF); wr(8'h6C, 32'h009);
    wr(8'h04, 32'h08);
    repeat (40) @(posedge clk);
    #1 rd(8'h68, 32'd10, "R4 divide by 4");

    // R4 divide by 1024 on channel 3
    wr(8'h1C, 32'h08); wr(8'h68, 32'd0); wr(8'h6C, 32'h029);
    wr(8'h2C, 32'h08);
    repeat (2048) @(posedge clk);
    #1 rd(8'h68, 32'd2, "R4 divide by 1024");
    wr(8'h1C, 32'h08);

    // R5 source selection on channel 2
    wr(8'h50, 32'hFFFF); wr(8'h5C, 32'h002);
    wr(8'h04, 32'h04);
    repeat (20) @(posedge clk);
    rd(8'h58, 32'd0, "R5 clock ignored when rtc selected");
    for (int k = 0; k < 7; k++) begin pulse_rtc(); pulse_ext(); end
    rd(8'h58, 32'd7, "R5 rtc pulses counted");
    wr(8'h5C, 32'h004);
    for (int k = 0; k < 3; k++) pulse_rtc();
    rd(8'h58, 32'd7, "R5 rtc ignored when ext selected");
    pulse_ext(); pulse_ext();
    rd(8'h58, 32'd9, "R5 ext pulses counted");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule